// File: doc/BRIEF.md
# Calendar Clock with Alarm Compare

This block keeps wall-clock time and date: seconds, minutes, hours, weekday, day of month, month and two-digit year. A built-in prescaler divides the system clock down to a one-second rollover. On each rollover a small update state machine advances the whole calendar in one step. One cycle later it compares the new seconds, minutes and hours against three alarm bytes. That compare cycle raises an update-done strobe and, when every field matches, an alarm strobe. The strobes go to interrupt flag logic outside the block. Register reads and writes come from an external bus adapter through a simple indexed port.

Each time and date byte is held either as packed BCD or as plain binary. Hours use either 24-hour form or 12-hour form with a PM flag. Both choices come from level inputs and may change while the block runs. Stored bytes are never converted: software rewrites them after a switch. A freeze input stops all advancing so that software can load a consistent time. An update-in-progress output goes high a fixed number of cycles before each rollover and stays high until the update has finished. A reader that sees it low knows it has time to read all fields safely.

The update state machine has three states. In S_IDLE it waits for the prescaler wrap. It takes the transition IDLE->ADV on a wrap while freeze is low. The transition ADV->CHECK is unconditional and loads the advanced calendar. The transition CHECK->IDLE is unconditional and emits the strobes.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read seconds 0, minutes 0, hours 0, weekday 1, day 1, month 1, year 0, and all three alarm bytes 0. Outputs uip_o, update_done_o and alarm_o are low. The read index map is: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday, 7 day of month, 8 month, 9 year. Indices 10 to 15 read 0.
- R2: With freeze low, update_done_o pulses for exactly one cycle once every CLK_PER_SEC cycles. In that cycle the read port already shows the advanced time, which is one second later than the time before.
- R3: Carries ripple in a fixed order. Seconds wrap 59 to 0 into minutes, minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into the day. The day advances the weekday (1..7, 7 wraps to 1) and the day of month. Past the month's last day, the day of month returns to 1 and the month advances (1..12). Past month 12, the month returns to 1 and the year advances (0..99, 99 wraps to 0).
- R4: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is a multiple of four (including 0) and 28 otherwise. All other months have 31 days.
- R5: When bin_i is 0, every field is stored and counted as packed BCD (tens in bits 7:4, units in bits 3:0). When bin_i is 1, every field is a plain binary count.
- R6: When h24_i is 1, hours run 0..23. When h24_i is 0, bits 6:0 hold 1..12 and bit 7 set means PM. The sequence runs 11 AM to 12 PM to 1 PM, and 11 PM to 12 AM with a day carry. The PM bit changes exactly at the 11 to 12 step.
- R7: While set_i is 1, the calendar does not advance and update_done_o stays low. Writes through wr_en_i are stored and read back unchanged.
- R8: uip_o is high for the last UIP_LEAD cycles before each rollover and through the two update cycles, UIP_LEAD + 2 cycles per second in all. It is high in the cycle where update_done_o pulses.
- R9: An alarm field matches when it equals the stored time byte, or when its bits 7 and 6 are both 1 (wildcard). A byte with only bit 7 set is not a wildcard. alarm_o needs all three fields to match.
- R10: alarm_o is asserted only in the update-done cycle. It stays low in the idle cycles after it, even while time and alarm still match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_i | input | 1 | Freeze: stops calendar advancing |
| bin_i | input | 1 | 1 = binary fields, 0 = packed BCD |
| h24_i | input | 1 | 1 = 24-hour form, 0 = 12-hour with PM in bit 7 |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 4 | Write register index |
| wr_data_i | input | 8 | Write data |
| rd_idx_i | input | 4 | Read register index |
| rd_data_o | output | 8 | Read data (combinational) |
| uip_o | output | 1 | Update in progress / imminent |
| alarm_o | output | 1 | One-cycle alarm match strobe |
| update_done_o | output | 1 | One-cycle update finished strobe |

## Verification
The bench builds the block with CLK_PER_SEC = 8 and UIP_LEAD = 2, so one simulated second takes eight cycles. This short period makes it cheap to load a state just before each rollover and watch one advance. The bench sweeps every month-end in leap and non-leap years, and every hour in 12-hour and 24-hour form, in both BCD and binary. It also sweeps all sixty alarm-second targets in both data modes. The same short period makes the uip window and the strobe spacing directly countable.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ADV   = 2'd1,
        S_CHECK = 2'd2
    } upd_state_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] dow;
        logic [7:0] dom;
        logic [7:0] mon;
        logic [7:0] yr;
    } cal_t;

    localparam int NUM_ALM = 3;

    // Stored byte to binary count
    function automatic logic [7:0] fld_to_bin(input logic [7:0] v, input logic bin_mode);
        logic [7:0] tens;
        tens = {4'd0, v[7:4]};
        return bin_mode ? v : (tens << 3) + (tens << 1) + {4'd0, v[3:0]};
    endfunction

    // Binary count to stored byte
    function automatic logic [7:0] fld_from_bin(input logic [7:0] b, input logic bin_mode);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = b / 8'd10;
        ones = b - tens * 8'd10;
        return bin_mode ? b : {tens[3:0], ones[3:0]};
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int CLK_PER_SEC = 32768,
    parameter int UIP_LEAD    = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic wrap_o,
    output logic lead_o
);
    localparam int CW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST  = CW'(CLK_PER_SEC - 1);
    localparam logic [CW-1:0] START = CW'(CLK_PER_SEC - UIP_LEAD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign wrap_o = (cnt_q == LAST);
    assign lead_o = (cnt_q >= START);

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  cal_t cur_i,
    input  logic bin_i,
    input  logic h24_i,
    output cal_t nxt_o
);
    logic [7:0] s, mi, h, h12, dw, dm, mo, y, dim;
    logic [7:0] ns, nm, nh, nh12, ndw, ndm, nmo, ny;
    logic       leap, c_s, c_m, c_h, c_d, c_mo, npm;

    always_comb begin
        s  = fld_to_bin(cur_i.sec, bin_i);
        mi = fld_to_bin(cur_i.min, bin_i);
        dw = fld_to_bin(cur_i.dow, bin_i);
        dm = fld_to_bin(cur_i.dom, bin_i);
        mo = fld_to_bin(cur_i.mon, bin_i);
        y  = fld_to_bin(cur_i.yr,  bin_i);
        h12 = fld_to_bin({1'b0, cur_i.hr[6:0]}, bin_i);
        if (h24_i) h = fld_to_bin(cur_i.hr, bin_i);
        else       h = ((h12 == 8'd12) ? 8'd0 : h12) + (cur_i.hr[7] ? 8'd12 : 8'd0);

        leap = (y[1:0] == 2'b00);
        case (mo)
            8'd2:                      dim = leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   dim = 8'd30;
            default:                   dim = 8'd31;
        endcase

        c_s  = (s >= 8'd59);
        c_m  = c_s && (mi >= 8'd59);
        c_h  = c_m && (h >= 8'd23);
        c_d  = c_h && (dm >= dim);
        c_mo = c_d && (mo >= 8'd12);

        ns  = c_s  ? 8'd0 : s + 8'd1;
        nm  = c_s  ? (c_m  ? 8'd0 : mi + 8'd1) : mi;
        nh  = c_m  ? (c_h  ? 8'd0 : h + 8'd1)  : h;
        ndw = c_h  ? ((dw >= 8'd7) ? 8'd1 : dw + 8'd1) : dw;
        ndm = c_h  ? (c_d  ? 8'd1 : dm + 8'd1) : dm;
        nmo = c_d  ? (c_mo ? 8'd1 : mo + 8'd1) : mo;
        ny  = c_mo ? ((y >= 8'd99) ? 8'd0 : y + 8'd1) : y;

        npm  = (nh >= 8'd12);
        nh12 = npm ? nh - 8'd12 : nh;
        if (nh12 == 8'd0) nh12 = 8'd12;

        nxt_o.sec = fld_from_bin(ns,  bin_i);
        nxt_o.min = fld_from_bin(nm,  bin_i);
        nxt_o.dow = fld_from_bin(ndw, bin_i);
        nxt_o.dom = fld_from_bin(ndm, bin_i);
        nxt_o.mon = fld_from_bin(nmo, bin_i);
        nxt_o.yr  = fld_from_bin(ny,  bin_i);
        if (h24_i) nxt_o.hr = fld_from_bin(nh, bin_i);
        else       nxt_o.hr = {npm, fld_from_bin(nh12, bin_i)[6:0]};
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
(
    input  logic [NUM_ALM-1:0][7:0] time_i,
    input  logic [NUM_ALM-1:0][7:0] alm_i,
    output logic                    match_o
);
    logic [NUM_ALM-1:0] hit;

    for (genvar g = 0; g < NUM_ALM; g++) begin : g_field
        assign hit[g] = (alm_i[g][7:6] == 2'b11) || (alm_i[g] == time_i[g]);
    end

    assign match_o = &hit;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int CLK_PER_SEC = 32768,
    parameter int UIP_LEAD    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic       bin_i,
    input  logic       h24_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_idx_i,
    input  logic [7:0] wr_data_i,
    input  logic [3:0] rd_idx_i,
    output logic [7:0] rd_data_o,
    output logic       uip_o,
    output logic       alarm_o,
    output logic       update_done_o
);
    upd_state_t state_q, state_d;
    cal_t       cal_q, cal_nxt;
    logic [NUM_ALM-1:0][7:0] alm_q;
    logic       wrap, lead, match;

    rtc_prescaler #(.CLK_PER_SEC(CLK_PER_SEC), .UIP_LEAD(UIP_LEAD)) u_pre (
        .clk(clk), .rst_n(rst_n), .wrap_o(wrap), .lead_o(lead));

    rtc_advance u_adv (.cur_i(cal_q), .bin_i(bin_i), .h24_i(h24_i), .nxt_o(cal_nxt));

    rtc_alarm_cmp u_cmp (
        .time_i({cal_q.hr, cal_q.min, cal_q.sec}),
        .alm_i(alm_q),
        .match_o(match));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (wrap && !set_i) state_d = S_ADV;
            S_ADV:   state_d = S_CHECK;
            S_CHECK: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Calendar and alarm storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= '{sec: 8'd0, min: 8'd0, hr: 8'd0, dow: 8'd1,
                       dom: 8'd1, mon: 8'd1, yr: 8'd0};
            alm_q <= '0;
        end else if (state_q == S_ADV) begin
            cal_q <= cal_nxt;
        end else if (wr_en_i) begin
            case (wr_idx_i)
                4'd0: cal_q.sec <= wr_data_i;
                4'd1: alm_q[0]  <= wr_data_i;
                4'd2: cal_q.min <= wr_data_i;
                4'd3: alm_q[1]  <= wr_data_i;
                4'd4: cal_q.hr  <= wr_data_i;
                4'd5: alm_q[2]  <= wr_data_i;
                4'd6: cal_q.dow <= wr_data_i;
                4'd7: cal_q.dom <= wr_data_i;
                4'd8: cal_q.mon <= wr_data_i;
                4'd9: cal_q.yr  <= wr_data_i;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        uip_o         = (lead && !set_i) || (state_q != S_IDLE);
        update_done_o = (state_q == S_CHECK);
        alarm_o       = (state_q == S_CHECK) && match;
        case (rd_idx_i)
            4'd0:    rd_data_o = cal_q.sec;
            4'd1:    rd_data_o = alm_q[0];
            4'd2:    rd_data_o = cal_q.min;
            4'd3:    rd_data_o = alm_q[1];
            4'd4:    rd_data_o = cal_q.hr;
            4'd5:    rd_data_o = alm_q[2];
            4'd6:    rd_data_o = cal_q.dow;
            4'd7:    rd_data_o = cal_q.dom;
            4'd8:    rd_data_o = cal_q.mon;
            4'd9:    rd_data_o = cal_q.yr;
            default: rd_data_o = 8'd0;
        endcase
    end

    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !wr_en_i && state_q != S_ADV) |=> $stable(cal_q));
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        update_done_o |=> !update_done_o);
    p_adv_needs_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && state_d == S_ADV) |-> wrap);
    p_uip_covers_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && state_d == S_ADV) |-> uip_o);
    p_done_has_uip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        update_done_o |-> uip_o);
    p_alarm_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> update_done_o);
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 8;
    localparam int LEAD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_i = 1'b0, bin_i = 1'b0, h24_i = 1'b1, wr_en_i = 1'b0;
    logic [3:0] wr_idx_i = '0, rd_idx_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic uip_o, alarm_o, update_done_o;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar #(.CLK_PER_SEC(DIV), .UIP_LEAD(LEAD)) dut (
        .clk(clk), .rst_n(rst_n), .set_i(set_i), .bin_i(bin_i), .h24_i(h24_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .uip_o(uip_o),
        .alarm_o(alarm_o), .update_done_o(update_done_o));

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int enc(input int v, input bit bm);
        return bm ? v : (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int enc_hr(input int h, input bit bm, input bit h24);
        int h12;
        if (h24) return enc(h, bm);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return ((h >= 12) ? 128 : 0) + enc(h12, bm);
    endfunction

    task automatic rd(input int idx, output int val);
        rd_idx_i = 4'(idx);
        #1;
        val = int'(rd_data_o);
    endtask

    task automatic wr(input int idx, input int val);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_data_i = 8'(val);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic load(input bit bm, input bit h24, input int s, input int m, input int h,
                        input int dw, input int dm, input int mo, input int y);
        @(negedge clk);
        set_i = 1'b1; bin_i = bm; h24_i = h24;
        repeat (3) @(negedge clk);
        wr(0, enc(s, bm)); wr(2, enc(m, bm)); wr(4, enc_hr(h, bm, h24));
        wr(6, enc(dw, bm)); wr(7, enc(dm, bm)); wr(8, enc(mo, bm)); wr(9, enc(y, bm));
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!update_done_o && n < 200);
        if (n >= 200) chk("R2 done timeout", 0, 1);
    endtask

    task automatic expect_cal(input string req, input bit bm, input bit h24, input int s,
                              input int m, input int h, input int dw, input int dm,
                              input int mo, input int y);
        int v;
        rd(0, v); chk({req, " sec"}, v, enc(s, bm));
        rd(2, v); chk({req, " min"}, v, enc(m, bm));
        rd(4, v); chk({req, " hour"}, v, enc_hr(h, bm, h24));
        rd(6, v); chk({req, " wday"}, v, enc(dw, bm));
        rd(7, v); chk({req, " mday"}, v, enc(dm, bm));
        rd(8, v); chk({req, " month"}, v, enc(mo, bm));
        rd(9, v); chk({req, " year"}, v, enc(y, bm));
    endtask

    function automatic int dim_of(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int v, n, u;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and index map
        chk("R1 uip", int'(uip_o), 0);
        chk("R1 done", int'(update_done_o), 0);
        chk("R1 alarm", int'(alarm_o), 0);
        expect_cal("R1 reset", 1'b0, 1'b1, 0, 0, 0, 1, 1, 1, 0);
        rd(1, v); chk("R1 alarm sec", v, 0);
        rd(3, v); chk("R1 alarm min", v, 0);
        rd(5, v); chk("R1 alarm hour", v, 0);
        for (int i = 10; i < 16; i++) begin rd(i, v); chk("R1 unused index", v, 0); end

        // R2 first advance, R8 uip window
        wait_done(n);
        chk("R2 alarm off", int'(alarm_o), 0);
        rd(0, v); chk("R2 first second", v, 1);
        for (int p = 0; p < 3; p++) begin
            n = 0; u = 0;
            do begin
                @(negedge clk); n++;
                if (uip_o) u++;
                if (update_done_o) chk("R8 uip in done cycle", int'(uip_o), 1);
            end while (!update_done_o && n < 50);
            chk("R2 period", n, DIV);
            chk("R8 uip cycles", u, LEAD + 2);
        end

        // R2 plain second and R3 minute/hour carry
        for (int bm = 0; bm < 2; bm++) begin
            load(bm[0], 1'b1, 30, 14, 5, 2, 9, 3, 11); set_i = 1'b0; wait_done(n);
            expect_cal("R2 plain", bm[0], 1'b1, 31, 14, 5, 2, 9, 3, 11);
            load(bm[0], 1'b1, 59, 14, 5, 2, 9, 3, 11); set_i = 1'b0; wait_done(n);
            expect_cal("R3 min carry", bm[0], 1'b1, 0, 15, 5, 2, 9, 3, 11);
            load(bm[0], 1'b1, 59, 59, 5, 2, 9, 3, 11); set_i = 1'b0; wait_done(n);
            expect_cal("R3 hour carry", bm[0], 1'b1, 0, 0, 6, 2, 9, 3, 11);
        end

        // R3 R4 R5 month-end sweep, both formats, leap and non-leap, year wrap
        for (int bm = 0; bm < 2; bm++)
            for (int yi = 0; yi < 3; yi++)
                for (int mo = 1; mo <= 12; mo++) begin
                    int y, d;
                    y = (yi == 0) ? 24 : (yi == 1) ? 99 : 0;
                    d = dim_of(mo, y);
                    load(bm[0], 1'b1, 59, 59, 23, 7, d, mo, y); set_i = 1'b0; wait_done(n);
                    expect_cal(bm[0] ? "R4 month end R5 bin" : "R4 month end R5 bcd", bm[0], 1'b1,
                               0, 0, 0, 1, 1, (mo % 12) + 1, (mo == 12) ? (y + 1) % 100 : y);
                end

        // R4 February 28 in leap years goes to 29
        for (int yi = 0; yi < 3; yi++) begin
            int y;
            y = yi * 4 + 8;
            load(1'b0, 1'b1, 59, 59, 23, 3, 28, 2, y); set_i = 1'b0; wait_done(n);
            expect_cal("R4 leap feb", 1'b0, 1'b1, 0, 0, 0, 4, 29, 2, y);
        end

        // R6 hour sweep in 12h and 24h forms, both formats
        for (int bm = 0; bm < 2; bm++)
            for (int hm = 0; hm < 2; hm++)
                for (int h = 0; h < 24; h++) begin
                    load(bm[0], hm[0], 59, 59, h, 3, 10, 5, 7); set_i = 1'b0; wait_done(n);
                    expect_cal(hm[0] ? "R6 hour 24h" : "R6 hour 12h", bm[0], hm[0], 0, 0,
                               (h + 1) % 24, (h == 23) ? 4 : 3, (h == 23) ? 11 : 10, 5, 7);
                end

        // R7 freeze with writes accepted
        load(1'b1, 1'b1, 40, 1, 2, 3, 4, 5, 6);
        wr(0, 41);
        n = 0;
        repeat (3 * DIV) begin
            @(negedge clk);
            if (update_done_o) n++;
        end
        chk("R7 no done while frozen", n, 0);
        rd(0, v); chk("R7 sec held / write kept", v, 41);
        rd(2, v); chk("R7 min held", v, 1);
        set_i = 1'b0; wait_done(n);
        rd(0, v); chk("R7 resumes", v, 42);

        // R9 R10 alarm sweep
        for (int bm = 0; bm < 2; bm++)
            for (int t = 0; t < 60; t++) begin
                int am, ah, expm;
                am = (t % 3 == 0) ? 8'hC0 : (t % 3 == 1) ? 8'hFF : enc((t == 0) ? 21 : 20, bm[0]);
                ah = (t % 4 == 0) ? enc(11, bm[0]) : (t % 4 == 1) ? enc(10, bm[0]) : 8'hC0;
                if (t % 7 == 5) am = 8'h80;
                expm = (t % 4 != 0 && t % 7 != 5) ? 1 : 0;
                load(bm[0], 1'b1, (t + 59) % 60, 20, 10, 1, 1, 1, 1);
                wr(1, enc(t, bm[0])); wr(3, am); wr(5, ah);
                set_i = 1'b0; wait_done(n);
                chk("R9 alarm match", int'(alarm_o), expm);
                u = 0;
                repeat (DIV - 2) begin
                    @(negedge clk);
                    if (alarm_o) u++;
                end
                chk("R10 alarm only in done cycle", u, 0);
            end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule